// File: doc/BRIEF.md
# PWM Junction-Temperature Decoder

This block reads a single-wire pulse-width-modulated temperature line driven by a power stage. The line arrives asynchronously, so the block first synchronises it to the system clock. It then times every cycle of the carrier. A period runs from one rising edge to the next. The high time runs from a rising edge to the falling edge that follows it. From these two counts it derives the duty fraction and maps it linearly onto a junction temperature in fixed point. The carrier is nominally near 9 kHz and the system clock is 100 MHz, so one result is expected per carrier period.

Periods far from nominal are discarded. The power stage signals overtemperature by holding the line high, and the block reports that as a fault flag and never as a reading. A line that stays low with no edges is reported on a separate timeout flag. After either condition the decoder re-arms on a rising edge and reports only periods that are complete.

Top module: `pwm_temp_decoder`

## Requirements
- R1: The input passes through a two-stage synchroniser. A high pulse as short as 3 clock cycles is measured with the correct high count.
- R2: The period is the number of clock cycles between two consecutive rising edges. The high time is the number of cycles from a rising edge to the next falling edge. Both are measured exactly for any period inside the acceptance window.
- R3: The duty code is q = floor(high * 2^12 / period), formed by a sequential divider that is started once for each accepted period.
- R4: `temp_o` is a two's-complement 13-bit value with 4 fraction bits (units of 1/16 °C), equal to floor(41549 * q / 2^16) + 322. This is a gain of 162.3 and an offset of 20.1 °C. The output is not clamped, so readings above 150 °C (2400 in these units) appear as computed.
- R5: `temp_valid_o` is high for exactly one clock per accepted period. `temp_o` changes only in the cycle that `temp_valid_o` is high and holds its value otherwise.
- R6: A period p is accepted only when NOM - floor(NOM/4) <= p <= NOM + floor(NOM/4). Any other period produces no strobe, and `temp_o` keeps its previous value.
- R7: If the line stays high for TIMEOUT cycles with no edge, `fault_o` goes to 1. No strobe is issued while `fault_o` is 1.
- R8: `fault_o` clears on the next falling edge. After that, the first rising edge only re-arms the decoder. The first strobe reports the period from that edge to the next rising edge.
- R9: If the line stays low for TIMEOUT cycles with no edge, `timeout_o` goes to 1 and no strobe is issued. The next rising edge clears the flag and re-arms the decoder, and the first strobe again reports a complete period that follows that edge.
- R10: While `rst` is high and just after it is released, `temp_o` is 0 and `temp_valid_o`, `fault_o` and `timeout_o` are 0.
- R11: The first rising edge after reset only arms the decoder. The period that ends at the second rising edge is the first one reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 100 MHz nominal |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | Asynchronous PWM temperature line |
| temp_o | output | 13 | Signed temperature, 4 fraction bits |
| temp_valid_o | output | 1 | One-cycle strobe for a new temperature |
| fault_o | output | 1 | Line held high: overtemperature |
| timeout_o | output | 1 | Line held low with no edges |

## Verification
The decoder is driven with carrier cycles whose high times range from a 3-cycle minimum pulse through mid duty to 82 % and 90 % duty. These patterns separate divider rounding, scaling errors and any clamp near 150 °C. Periods exactly on both window limits and one cycle outside them show whether the acceptance test is inclusive and correctly placed. Periods at different lengths inside the window separate a correct rise-to-rise count from one that assumes the nominal period. A long high hold and a long low silence, each followed by fresh cycles, separate the two flags from each other. They also show whether re-arming correctly discards the period that spans the condition and reports the first complete one after it.

// File: rtl/pwm_temp_pkg.sv
package pwm_temp_pkg;

  typedef enum logic [1:0] {
    LS_WAIT = 2'd0,
    LS_RUN  = 2'd1,
    LS_OVT  = 2'd2,
    LS_LOST = 2'd3
  } line_st_e;

  function automatic logic in_span(input int unsigned v,
                                   input int unsigned lo,
                                   input int unsigned hi);
    return (v >= lo) && (v <= hi);
  endfunction

endpackage

// File: rtl/pwm_edge_sync.sv
module pwm_edge_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);

  logic [SYNC_N-1:0] sh;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      prev   <= 1'b0;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      sh     <= {sh[SYNC_N-2:0], pin_i};
      prev   <= sh[SYNC_N-1];
      rise_o <= sh[SYNC_N-1] & ~prev;
      fall_o <= ~sh[SYNC_N-1] & prev;
    end
  end

  assign level_o = prev;

  // R1: an edge pulse is one or the other, never both
  p_edge_excl_r1: assert property (@(posedge clk) disable iff (rst)
    !(rise_o && fall_o));

  // R1: a rising pulse is reported with the level already high
  p_rise_level_r1: assert property (@(posedge clk) disable iff (rst)
    rise_o |-> level_o);

endmodule

// File: rtl/pwm_period_meter.sv
module pwm_period_meter
  import pwm_temp_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int WIN_LO  = 8334,
  parameter int WIN_HI  = 13888,
  parameter int TIMEOUT = 27778
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             level_i,
  input  logic             rise_i,
  input  logic             fall_i,
  output logic             start_o,
  output logic [CNT_W-1:0] hi_len_o,
  output logic [CNT_W-1:0] per_len_o,
  output logic             fault_o,
  output logic             lost_o
);

  localparam int TO_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}} - 1'b1;

  line_st_e         st;
  logic [CNT_W-1:0] per_cnt;
  logic [CNT_W-1:0] hi_cap;
  logic [TO_W-1:0]  idle_cnt;
  logic [CNT_W-1:0] len_now;
  logic             win_ok;
  logic             idle_hit;
  logic             any_edge;

  assign len_now  = per_cnt + 1'b1;
  assign win_ok   = in_span(32'(len_now), WIN_LO, WIN_HI);
  assign idle_hit = (idle_cnt == TO_W'(TIMEOUT));
  assign any_edge = rise_i | fall_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= LS_WAIT;
      per_cnt   <= '0;
      hi_cap    <= '0;
      idle_cnt  <= '0;
      start_o   <= 1'b0;
      hi_len_o  <= '0;
      per_len_o <= '0;
    end else begin
      start_o <= 1'b0;

      if (any_edge)        idle_cnt <= '0;
      else if (!idle_hit)  idle_cnt <= idle_cnt + 1'b1;

      if (rise_i)                 per_cnt <= '0;
      else if (per_cnt != CNT_TOP) per_cnt <= per_cnt + 1'b1;

      if (fall_i) hi_cap <= len_now;

      case (st)
        LS_WAIT: begin
          if (rise_i) st <= LS_RUN;
          else if (idle_hit && !any_edge) st <= level_i ? LS_OVT : LS_LOST;
        end
        LS_RUN: begin
          if (rise_i) begin
            if (win_ok) begin
              start_o   <= 1'b1;
              hi_len_o  <= hi_cap;
              per_len_o <= len_now;
            end
          end else if (idle_hit && !any_edge) begin
            st <= level_i ? LS_OVT : LS_LOST;
          end
        end
        LS_OVT: begin
          if (fall_i) st <= LS_WAIT;
        end
        LS_LOST: begin
          if (rise_i) st <= LS_RUN;
          else if (idle_hit && !any_edge && level_i) st <= LS_OVT;
        end
        default: st <= LS_WAIT;
      endcase
    end
  end

  assign fault_o = (st == LS_OVT);
  assign lost_o  = (st == LS_LOST);

  // R7: the two line conditions are exclusive
  p_flags_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(fault_o && lost_o));

  // R7: no measurement is launched while the line is held high
  p_no_start_fault_r7: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> !start_o);

  // R6: launched periods lie inside the window
  p_window_r6: assert property (@(posedge clk) disable iff (rst)
    start_o |-> (per_len_o >= CNT_W'(WIN_LO)) && (per_len_o <= CNT_W'(WIN_HI)));

  // R8: a falling edge ends the fault
  p_fault_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (fault_o && fall_i) |=> !fault_o);

  // R9: a rising edge ends the timeout
  p_lost_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (lost_o && rise_i) |=> !lost_o);

  // R9: no measurement is launched while the line is silent
  p_no_start_lost_r9: assert property (@(posedge clk) disable iff (rst)
    lost_o |-> !start_o);

endmodule

// File: rtl/pwm_duty_divider.sv
module pwm_duty_divider #(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] hi_i,
  input  logic [CNT_W-1:0] per_i,
  output logic             done_o,
  output logic [FRAC_W:0]  quo_o
);

  localparam int Q_W   = FRAC_W + 1;
  localparam int IDX_W = $clog2(Q_W);

  logic [CNT_W:0]   rem;
  logic [CNT_W-1:0] den;
  logic [IDX_W-1:0] idx;
  logic             busy;
  logic             ge;
  logic [CNT_W:0]   rem_nx;

  assign ge     = (rem >= {1'b0, den});
  assign rem_nx = ge ? (rem - {1'b0, den}) : rem;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem    <= '0;
      den    <= '0;
      idx    <= '0;
      busy   <= 1'b0;
      done_o <= 1'b0;
      quo_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        rem   <= {1'b0, hi_i};
        den   <= per_i;
        idx   <= IDX_W'(Q_W - 1);
        busy  <= 1'b1;
        quo_o <= '0;
      end else if (busy) begin
        rem   <= {rem_nx[CNT_W-1:0], 1'b0};
        quo_o <= {quo_o[Q_W-2:0], ge};
        idx   <= idx - 1'b1;
        if (idx == '0) begin
          busy   <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  // R3: a new division never arrives while one is running
  p_no_overlap_r3: assert property (@(posedge clk) disable iff (rst)
    start_i |-> !busy);

  // R2: high time never exceeds the period handed over
  p_hi_le_per_r2: assert property (@(posedge clk) disable iff (rst)
    start_i |-> (hi_i <= per_i));

  // R3: the duty code never exceeds unity
  p_quo_range_r3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (quo_o <= Q_W'(1 << FRAC_W)));

endmodule

// File: rtl/pwm_temp_scale.sv
module pwm_temp_scale #(
  parameter int FRAC_W   = 12,
  parameter int GAIN_Q   = 41549,
  parameter int GAIN_FR  = 8,
  parameter int OFFSET_Q = 322,
  parameter int OUT_FR   = 4,
  parameter int OUT_W    = 13
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    done_i,
  input  logic [FRAC_W:0]         quo_i,
  output logic signed [OUT_W-1:0] temp_o,
  output logic                    valid_o
);

  localparam int Q_W    = FRAC_W + 1;
  localparam int GAIN_W = $clog2(GAIN_Q + 1);
  localparam int PROD_W = GAIN_W + Q_W;
  localparam int SHIFT  = FRAC_W + GAIN_FR - OUT_FR;

  logic [PROD_W-1:0] prod;
  logic [OUT_W-1:0]  scaled;

  assign prod   = PROD_W'(GAIN_Q) * PROD_W'(quo_i);
  assign scaled = OUT_W'(prod >> SHIFT) + OUT_W'(OFFSET_Q);

  always_ff @(posedge clk) begin
    if (rst) begin
      temp_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= done_i;
      if (done_i) temp_o <= scaled;
    end
  end

  // R5: the strobe is a single-cycle pulse
  p_single_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R5: the reading only moves with the strobe
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> $stable(temp_o));

  // R4: a reading is never below the offset
  p_floor_r4: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (temp_o >= $signed({1'b0, OUT_W'(OFFSET_Q)})));

endmodule

// File: rtl/pwm_temp_decoder.sv
module pwm_temp_decoder #(
  parameter int CNT_W      = 16,
  parameter int NOM_PERIOD = 11111,
  parameter int TIMEOUT    = 27778,
  parameter int SYNC_N     = 2,
  parameter int FRAC_W     = 12,
  parameter int GAIN_Q     = 41549,
  parameter int GAIN_FR    = 8,
  parameter int OFFSET_Q   = 322,
  parameter int OUT_FR     = 4,
  parameter int OUT_W      = 13
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    pwm_in,
  output logic signed [OUT_W-1:0] temp_o,
  output logic                    temp_valid_o,
  output logic                    fault_o,
  output logic                    timeout_o
);

  localparam int WIN_LO = NOM_PERIOD - NOM_PERIOD / 4;
  localparam int WIN_HI = NOM_PERIOD + NOM_PERIOD / 4;

  logic             lvl, rise, fall;
  logic             start;
  logic [CNT_W-1:0] hi_len, per_len;
  logic             div_done;
  logic [FRAC_W:0]  quo;

  pwm_edge_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .pin_i(pwm_in),
    .level_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  pwm_period_meter #(
    .CNT_W(CNT_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI), .TIMEOUT(TIMEOUT)
  ) u_meter (
    .clk(clk), .rst(rst), .level_i(lvl), .rise_i(rise), .fall_i(fall),
    .start_o(start), .hi_len_o(hi_len), .per_len_o(per_len),
    .fault_o(fault_o), .lost_o(timeout_o)
  );

  pwm_duty_divider #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_div (
    .clk(clk), .rst(rst), .start_i(start), .hi_i(hi_len), .per_i(per_len),
    .done_o(div_done), .quo_o(quo)
  );

  pwm_temp_scale #(
    .FRAC_W(FRAC_W), .GAIN_Q(GAIN_Q), .GAIN_FR(GAIN_FR),
    .OFFSET_Q(OFFSET_Q), .OUT_FR(OUT_FR), .OUT_W(OUT_W)
  ) u_scale (
    .clk(clk), .rst(rst), .done_i(div_done), .quo_i(quo),
    .temp_o(temp_o), .valid_o(temp_valid_o)
  );

  // R7: a reading is never strobed under either line condition
  p_no_strobe_flag_r7: assert property (@(posedge clk) disable iff (rst)
    temp_valid_o |-> !(fault_o || timeout_o));

endmodule

// File: tb/pwm_temp_decoder_bench.sv
module pwm_temp_decoder_bench;

  localparam int NOM = 400;
  localparam int TO  = 1000;
  localparam int LO  = NOM - NOM / 4;
  localparam int HI  = NOM + NOM / 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pin = 1'b0;
  logic signed [12:0] temp;
  logic vld, flt, tmo;

  always #5 clk = ~clk;

  pwm_temp_decoder #(
    .NOM_PERIOD(NOM), .TIMEOUT(TO)
  ) u_pwm_temp_decoder (
    .clk(clk), .rst(rst), .pwm_in(pin), .temp_o(temp),
    .temp_valid_o(vld), .fault_o(flt), .timeout_o(tmo)
  );

  int    total = 0;
  int    bad = 0;
  int    n_seen = 0;
  int    max_seen = 0;
  bit    running = 1'b1;
  int    exp_q[$];
  string tag_q[$];
  bit    have_prev = 1'b0;
  int    prev_h = 0;
  int    prev_p = 0;
  string prev_tag = "";

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int exp_temp(input int h, input int p);
    int q;
    q = (h * 4096) / p;
    return (41549 * q) / 65536 + 322;
  endfunction

  // model: a rising edge completes the pending period if the decoder is armed
  task automatic close_prev();
    if (have_prev && prev_p >= LO && prev_p <= HI) begin
      exp_q.push_back(exp_temp(prev_h, prev_p));
      tag_q.push_back(prev_tag);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int h, input int p, input string tag);
    close_prev();
    have_prev = 1'b1;
    prev_h = h;
    prev_p = p;
    prev_tag = tag;
    pin = 1'b1;
    step(h);
    pin = 1'b0;
    step(p - h);
  endtask

  task automatic flush(input int n);
    step(n);
    prev_p += n;
    chk(exp_q.size() == 0, "R5 all expected strobes delivered", exp_q.size(), 0);
  endtask

  task automatic hold_high(input int n, input int low_after);
    close_prev();
    have_prev = 1'b0;
    pin = 1'b1;
    step(TO + 50);
    chk(flt == 1'b1, "R7 fault after long high", int'(flt), 1);
    chk(tmo == 1'b0, "R7 timeout clear during high", int'(tmo), 0);
    step(n - TO - 50);
    pin = 1'b0;
    step(20);
    chk(flt == 1'b0, "R8 fault cleared by fall", int'(flt), 0);
    step(low_after - 20);
  endtask

  task automatic hold_low(input int n);
    have_prev = 1'b0;
    pin = 1'b0;
    step(TO + 50);
    chk(tmo == 1'b1, "R9 timeout after silence", int'(tmo), 1);
    chk(flt == 1'b0, "R9 fault clear during silence", int'(flt), 0);
    step(n - TO - 50);
  endtask

  // per-clock comparison against the model queue
  always @(negedge clk) begin
    int e;
    string t;
    if (!rst && running && vld) begin
      n_seen++;
      if (int'(temp) > max_seen) max_seen = int'(temp);
      if (flt || tmo) chk(1'b0, "R7 strobe under a flag", 1, 0);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected strobe", int'(temp), -1);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(int'(temp) == e, t, int'(temp), e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (running) begin
      running = 1'b0;
      chk(1'b0, "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    step(10);
    chk(vld == 1'b0, "R10 valid low in reset", int'(vld), 0);
    chk(int'(temp) == 0, "R10 temp zero in reset", int'(temp), 0);
    rst = 1'b0;
    step(1);
    chk(flt == 1'b0, "R10 fault low after reset", int'(flt), 0);
    chk(tmo == 1'b0, "R10 timeout low after reset", int'(tmo), 0);

    pulse(3, 400, "R1 minimum pulse");
    chk(n_seen == 0, "R11 first period after reset not reported", n_seen, 0);
    pulse(40, 400, "R3 low duty");
    pulse(200, 400, "R3 half duty");
    pulse(328, 400, "R4 82 percent duty");
    pulse(360, 400, "R4 90 percent duty");
    pulse(100, LO, "R6 lower window limit");
    pulse(100, HI, "R6 upper window limit");
    pulse(100, LO - 1, "R6 below window");
    pulse(100, HI + 1, "R6 above window");
    pulse(120, 350, "R2 short period");
    pulse(200, 450, "R2 long period");
    pulse(50, 400, "R2 closing period");
    flush(80);
    chk(max_seen > 2400, "R4 no clamp above 150 C", max_seen, 2401);

    hold_high(1500, 200);
    pulse(100, 400, "R8 first period after fault");
    pulse(150, 400, "R8 second period after fault");
    pulse(10, 400, "R8 closing period");
    flush(80);

    hold_low(1500);
    pulse(80, 400, "R9 first period after silence");
    chk(tmo == 1'b0, "R9 timeout cleared by rise", int'(tmo), 0);
    pulse(90, 400, "R9 second period after silence");
    pulse(5, 400, "R9 closing period");
    flush(80);

    running = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule